// File: doc/BRIEF.md
# Dual-Width Execute Datapath

This block is the execute stage of a pipelined integer core. Every instruction carries its own width flag, and the block runs that instruction at either the full 32-bit width or the narrow 16-bit width. It takes two register operands, two forwarded values (one from the memory stage, one from write-back) and a 16-bit immediate. It performs add, bitwise AND, left shift or equality compare, and registers the result, a branch-taken flag and the store data for the next stage.

On a narrow instruction the block keeps the upper half of its datapath still. The upper bits of the operand selectors hold their last wide value. The shifter's upper control lines stay idle. The adder's carry chain is cut at the half-word boundary. The output register splits its load enables so that its upper half only loads on wide instructions. Software that mixes 16-bit data with 32-bit pointers therefore toggles the upper-half nodes only on the instructions that need them.

Top module: `dwx_exec`

## Requirements
- R1: While `rstN` is low, and on the first clock edge after it, every output is zero.
- R2: `inWide` = 1 selects a 32-bit operation and `inWide` = 0 a 16-bit one. `inOp` codes: 0 add, 1 AND, 2 shift left, 3 equality compare.
- R3: A wide add returns (A+B) mod 2^32. A narrow add returns (A[15:0]+B[15:0]) mod 2^16 in the low half, and no carry leaves bit 15.
- R4: AND returns A&B over the active width.
- R5: A wide shift returns A << B[4:0]. A narrow shift returns (A[15:0] << B[3:0]) mod 2^16 in the low half, and B[4] is ignored.
- R6: A compare sets `outTaken` one cycle later when the operands are equal: all 32 bits for wide, only the low 16 bits for narrow. The result low half becomes 1 or 0 to match, and a wide compare clears the high half.
- R7: The low half of `outResult` loads on every valid instruction. The high half loads only on valid wide instructions and otherwise keeps its value.
- R8: `outStoreData` takes operand B only when `inValid` and `inStore` are both 1. Its high half additionally requires `inWide` = 1.
- R9: `inSelA` codes: 0 `regA`, 1 `fwdMem`, 2 `fwdWb`, 3 `regA`. `inSelB` codes: 0 `regB`, 1 `fwdMem`, 2 `fwdWb`, 3 immediate.
- R10: On a wide instruction the immediate is sign-extended from bit 15. On a narrow one it is the low half as is.
- R11: `outValid` repeats `inValid` one cycle later. A cycle with `inValid` = 0 leaves `outResult` and `outStoreData` unchanged and gives `outTaken` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Instruction present this cycle |
| inWide | input | 1 | 1 = 32-bit operation, 0 = 16-bit |
| inOp | input | 2 | Operation code |
| inStore | input | 1 | Instruction is a store |
| inSelA | input | 2 | Operand A source select |
| inSelB | input | 2 | Operand B source select |
| regA | input | 32 | Register file value for A |
| regB | input | 32 | Register file value for B |
| fwdMem | input | 32 | Forward from memory stage |
| fwdWb | input | 32 | Forward from write-back stage |
| imm | input | 16 | Immediate field |
| outValid | output | 1 | Registered valid |
| outResult | output | 32 | Registered result |
| outTaken | output | 1 | Registered branch-taken flag |
| outStoreData | output | 32 | Registered store data |

## Verification
Every result of this block comes from a single register, so the outputs for an instruction present at one rising edge are due right after that edge and hold until the next one. The bench drives inputs on the falling edge, moves its reference model forward at the following rising edge, and compares all four outputs at the next falling edge. By then the registers have settled and the next instruction has not yet been clocked in. Held upper halves and held store data are checked in the same way: the model keeps its previous value, and any stray load shows up as a mismatch one cycle later.

// File: rtl/dwx_pkg.sv
package dwx_pkg;

  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_AND = 2'd1,
    OP_SHL = 2'd2,
    OP_CMP = 2'd3
  } dwx_op_e;

  typedef enum logic [1:0] {
    SRC_REG = 2'd0,
    SRC_MEM = 2'd1,
    SRC_WB  = 2'd2,
    SRC_IMM = 2'd3
  } dwx_src_e;

  typedef struct packed {
    logic    loadLo;
    logic    loadHi;
    logic    storeLo;
    logic    storeHi;
    logic    wide;
    logic    isCmp;
    dwx_op_e op;
  } dwx_strobe_t;

endpackage

// File: rtl/dwx_ctrl.sv
module dwx_ctrl
  import dwx_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        inWide,
  input  logic        inStore,
  input  logic [1:0]  inOp,
  output dwx_strobe_t strobe,
  output logic        outValid
);

  always_comb begin
    strobe.op      = dwx_op_e'(inOp);
    strobe.wide    = inWide;
    strobe.loadLo  = inValid;
    strobe.loadHi  = inValid & inWide;
    strobe.storeLo = inValid & inStore;
    strobe.storeHi = inValid & inStore & inWide;
    strobe.isCmp   = inValid & (dwx_op_e'(inOp) == OP_CMP);
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  // R11: valid is delayed by exactly one stage
  a_r11_valid_delay: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> outValid == $past(inValid));

endmodule

// File: rtl/dwx_cla_adder.sv
module dwx_cla_adder #(
  parameter int WIDTH = 32,
  parameter int GROUP = 4
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cutHalf,
  output logic [WIDTH-1:0] sum
);

  localparam int GROUPS = WIDTH / GROUP;
  localparam int HALF_GROUPS = GROUPS / 2;

  logic [GROUPS-1:0] grpGen;
  logic [GROUPS-1:0] grpProp;
  logic [GROUPS:0]   grpCarry;

  // per-group generate/propagate and local sum
  for (genvar gi = 0; gi < GROUPS; gi++) begin : g_group
    logic [GROUP-1:0] bitGen;
    logic [GROUP-1:0] bitProp;
    assign bitGen  = a[gi*GROUP +: GROUP] & b[gi*GROUP +: GROUP];
    assign bitProp = a[gi*GROUP +: GROUP] ^ b[gi*GROUP +: GROUP];

    always_comb begin
      logic gAcc;
      logic pAcc;
      gAcc = 1'b0;
      pAcc = 1'b1;
      for (int j = 0; j < GROUP; j++) begin
        gAcc = bitGen[j] | (bitProp[j] & gAcc);
        pAcc = pAcc & bitProp[j];
      end
      grpGen[gi]  = gAcc;
      grpProp[gi] = pAcc;
    end

    always_comb begin
      logic c;
      c = grpCarry[gi];
      for (int j = 0; j < GROUP; j++) begin
        sum[gi*GROUP + j] = bitProp[j] ^ c;
        c = bitGen[j] | (bitProp[j] & c);
      end
    end
  end

  // upper-level lookahead across groups, cut at the half boundary
  always_comb begin
    logic c;
    c = 1'b0;
    grpCarry[0] = 1'b0;
    for (int i = 0; i < GROUPS; i++) begin
      c = grpGen[i] | (grpProp[i] & c);
      if (cutHalf && (i + 1 == HALF_GROUPS)) c = 1'b0;
      grpCarry[i+1] = c;
    end
  end

endmodule

// File: rtl/dwx_shifter.sv
module dwx_shifter #(
  parameter int WIDTH = 32,
  localparam int SHW = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] value,
  input  logic [SHW-1:0]   amount,
  input  logic             wide,
  output logic [WIDTH-1:0] result
);

  localparam int HALF = WIDTH / 2;

  logic [SHW-1:0]   amtLo;
  logic [SHW-1:0]   amtHi;
  logic [WIDTH-1:0] stage [SHW+1];

  // upper control lines stay idle in narrow mode
  assign amtLo = wide ? amount : {1'b0, amount[SHW-2:0]};
  assign amtHi = wide ? amount : '0;
  assign stage[0] = value;

  for (genvar s = 0; s < SHW; s++) begin : g_stage
    localparam int K = 1 << s;
    if (K < HALF) begin : g_small
      assign stage[s+1][HALF-1:0] = amtLo[s] ?
        {stage[s][HALF-1-K:0], {K{1'b0}}} : stage[s][HALF-1:0];
      assign stage[s+1][WIDTH-1:HALF] = amtHi[s] ?
        stage[s][WIDTH-1-K:HALF-K] : stage[s][WIDTH-1:HALF];
    end else begin : g_half
      assign stage[s+1][HALF-1:0] = amtLo[s] ? '0 : stage[s][HALF-1:0];
      assign stage[s+1][WIDTH-1:HALF] = amtHi[s] ?
        stage[s][HALF-1:0] : stage[s][WIDTH-1:HALF];
    end
  end

  assign result = stage[SHW];

endmodule

// File: rtl/dwx_datapath.sv
module dwx_datapath
  import dwx_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int HALF = WIDTH / 2,
  localparam int SHW = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  dwx_strobe_t      strobe,
  input  logic [1:0]       selA,
  input  logic [1:0]       selB,
  input  logic [WIDTH-1:0] regA,
  input  logic [WIDTH-1:0] regB,
  input  logic [WIDTH-1:0] fwdMem,
  input  logic [WIDTH-1:0] fwdWb,
  input  logic [HALF-1:0]  imm,
  output logic [WIDTH-1:0] outResult,
  output logic             outTaken,
  output logic [WIDTH-1:0] outStoreData
);

  logic [WIDTH-1:0] fullA, fullB, immExt;
  logic [WIDTH-1:0] opA, opB;
  logic [WIDTH-HALF-1:0] heldHiA, heldHiB;
  logic [WIDTH-1:0] addSum, shlRes, aluRes;
  logic eqLo, eqHi, isEqual;

  assign immExt = {{(WIDTH-HALF){imm[HALF-1]}}, imm};

  always_comb begin
    unique case (dwx_src_e'(selA))
      SRC_MEM: fullA = fwdMem;
      SRC_WB:  fullA = fwdWb;
      default: fullA = regA;
    endcase
    unique case (dwx_src_e'(selB))
      SRC_MEM: fullB = fwdMem;
      SRC_WB:  fullB = fwdWb;
      SRC_IMM: fullB = immExt;
      default: fullB = regB;
    endcase
  end

  // upper halves of the operand buses hold on narrow operations
  assign opA = {strobe.wide ? fullA[WIDTH-1:HALF] : heldHiA, fullA[HALF-1:0]};
  assign opB = {strobe.wide ? fullB[WIDTH-1:HALF] : heldHiB, fullB[HALF-1:0]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldHiA <= '0;
      heldHiB <= '0;
    end else if (strobe.loadHi) begin
      heldHiA <= fullA[WIDTH-1:HALF];
      heldHiB <= fullB[WIDTH-1:HALF];
    end
  end

  dwx_cla_adder #(.WIDTH(WIDTH), .GROUP(4)) u_adder (
    .a(opA), .b(opB), .cutHalf(!strobe.wide), .sum(addSum)
  );

  dwx_shifter #(.WIDTH(WIDTH)) u_shifter (
    .value(opA), .amount(opB[SHW-1:0]), .wide(strobe.wide), .result(shlRes)
  );

  assign eqLo    = opA[HALF-1:0] == opB[HALF-1:0];
  assign eqHi    = opA[WIDTH-1:HALF] == opB[WIDTH-1:HALF];
  assign isEqual = eqLo & (eqHi | !strobe.wide);

  always_comb begin
    unique case (strobe.op)
      OP_ADD:  aluRes = addSum;
      OP_AND:  aluRes = opA & opB;
      OP_SHL:  aluRes = shlRes;
      default: aluRes = {{(WIDTH-1){1'b0}}, isEqual};
    endcase
  end

  // output register with split half-word enables
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outResult    <= '0;
      outTaken     <= 1'b0;
      outStoreData <= '0;
    end else begin
      if (strobe.loadLo)  outResult[HALF-1:0]        <= aluRes[HALF-1:0];
      if (strobe.loadHi)  outResult[WIDTH-1:HALF]    <= aluRes[WIDTH-1:HALF];
      if (strobe.storeLo) outStoreData[HALF-1:0]     <= opB[HALF-1:0];
      if (strobe.storeHi) outStoreData[WIDTH-1:HALF] <= opB[WIDTH-1:HALF];
      outTaken <= strobe.isCmp & isEqual;
    end
  end

  // R7: high result half keeps its value unless a wide op loads it
  a_r7_hi_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadHi |=> $stable(outResult[WIDTH-1:HALF]));

  // R8: store data untouched by non-store cycles
  a_r8_store_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.storeLo |=> $stable(outStoreData));

  // R11: idle cycle changes nothing and never signals a branch
  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadLo |=> ($stable(outResult) && !outTaken));

  // R6: a taken flag only follows a compare
  a_r6_taken_src: assert property (@(posedge clk) disable iff (!rstN)
    outTaken |-> $past(strobe.isCmp));

  // R3: narrow add never carries out of the low half
  a_r3_narrow_add: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadLo && !strobe.wide && strobe.op == OP_ADD) |=>
      outResult[HALF-1:0] == $past(fullA[HALF-1:0] + fullB[HALF-1:0]));

endmodule

// File: rtl/dwx_exec.sv
module dwx_exec
  import dwx_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int HALF = WIDTH / 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             inWide,
  input  logic [1:0]       inOp,
  input  logic             inStore,
  input  logic [1:0]       inSelA,
  input  logic [1:0]       inSelB,
  input  logic [WIDTH-1:0] regA,
  input  logic [WIDTH-1:0] regB,
  input  logic [WIDTH-1:0] fwdMem,
  input  logic [WIDTH-1:0] fwdWb,
  input  logic [HALF-1:0]  imm,
  output logic             outValid,
  output logic [WIDTH-1:0] outResult,
  output logic             outTaken,
  output logic [WIDTH-1:0] outStoreData
);

  dwx_strobe_t strobe;

  dwx_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inWide(inWide),
    .inStore(inStore), .inOp(inOp), .strobe(strobe), .outValid(outValid)
  );

  dwx_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .selA(inSelA), .selB(inSelB),
    .regA(regA), .regB(regB), .fwdMem(fwdMem), .fwdWb(fwdWb), .imm(imm),
    .outResult(outResult), .outTaken(outTaken), .outStoreData(outStoreData)
  );

endmodule

// File: tb/dwx_exec_tb.sv
module dwx_exec_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic        inValid, inWide, inStore;
  logic [1:0]  inOp, inSelA, inSelB;
  logic [31:0] regA, regB, fwdMem, fwdWb;
  logic [15:0] imm;
  logic        outValid, outTaken;
  logic [31:0] outResult, outStoreData;

  int checks = 0;
  int errors = 0;

  logic [31:0] expRes, expStore;
  logic        expTaken, expValid;

  always #5 clk = ~clk;

  dwx_exec u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inWide(inWide), .inOp(inOp),
    .inStore(inStore), .inSelA(inSelA), .inSelB(inSelB), .regA(regA),
    .regB(regB), .fwdMem(fwdMem), .fwdWb(fwdWb), .imm(imm),
    .outValid(outValid), .outResult(outResult), .outTaken(outTaken),
    .outStoreData(outStoreData)
  );

  task automatic check(input string tag, input string field,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, field, act, exp);
    end
  endtask

  task automatic compareAll(input string tag);
    check("R11", "valid", {31'b0, outValid}, {31'b0, expValid});
    check(tag, "result", outResult, expRes);
    check("R6", "taken", {31'b0, outTaken}, {31'b0, expTaken});
    check("R8", "storeData", outStoreData, expStore);
  endtask

  // reference model: one instruction per clock
  task automatic step(input bit v, input bit w, input bit st, input logic [1:0] op,
                      input logic [1:0] sa, input logic [1:0] sb,
                      input logic [31:0] ra, input logic [31:0] rb,
                      input logic [31:0] fm, input logic [31:0] fw,
                      input logic [15:0] im, input string tag);
    logic [31:0] a, b, r;
    logic eq;
    inValid = v; inWide = w; inStore = st; inOp = op; inSelA = sa; inSelB = sb;
    regA = ra; regB = rb; fwdMem = fm; fwdWb = fw; imm = im;
    @(posedge clk);
    a = (sa == 2'd1) ? fm : (sa == 2'd2) ? fw : ra;
    b = (sb == 2'd1) ? fm : (sb == 2'd2) ? fw :
        (sb == 2'd3) ? {{16{im[15]}}, im} : rb;
    eq = w ? (a == b) : (a[15:0] == b[15:0]);
    if (w) begin
      case (op)
        2'd0: r = a + b;
        2'd1: r = a & b;
        2'd2: r = a << b[4:0];
        default: r = {31'b0, eq};
      endcase
      if (v) expRes = r;
      if (v && st) expStore = b;
    end else begin
      case (op)
        2'd0: r = {16'b0, a[15:0] + b[15:0]};
        2'd1: r = {16'b0, a[15:0] & b[15:0]};
        2'd2: r = {16'b0, a[15:0] << b[3:0]};
        default: r = {31'b0, eq};
      endcase
      if (v) expRes[15:0] = r[15:0];
      if (v && st) expStore[15:0] = b[15:0];
    end
    expTaken = v && (op == 2'd3) && eq;
    expValid = v;
    @(negedge clk);
    compareAll(tag);
  endtask

  function automatic string opTag(input logic [1:0] op);
    case (op)
      2'd0: return "R3";
      2'd1: return "R4";
      2'd2: return "R5";
      default: return "R6";
    endcase
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    rstN = 1'b0;
    inValid = 1'b1; inWide = 1'b1; inStore = 1'b1; inOp = 2'd0;
    inSelA = 2'd0; inSelB = 2'd0;
    regA = 32'h1234_5678; regB = 32'h1111_1111; fwdMem = '1; fwdWb = '1;
    imm = 16'hFFFF;
    repeat (3) @(negedge clk);
    // R1: reset state with active inputs
    check("R1", "valid", {31'b0, outValid}, 32'd0);
    check("R1", "result", outResult, 32'd0);
    check("R1", "taken", {31'b0, outTaken}, 32'd0);
    check("R1", "storeData", outStoreData, 32'd0);
    expRes = '0; expStore = '0; expTaken = 1'b0; expValid = 1'b0;
    rstN = 1'b1;

    // R2 and R7: wide op loads the high half, narrow op keeps it
    step(1, 1, 0, 2'd0, 0, 0, 32'hAAAA_0001, 32'h1111_0002, 0, 0, 0, "R2");
    step(1, 0, 0, 2'd0, 0, 0, 32'h5555_0003, 32'h7777_0004, 0, 0, 0, "R7");
    // R3: carries at the half boundary
    step(1, 0, 0, 2'd0, 0, 0, 32'h0000_FFFF, 32'h0000_0001, 0, 0, 0, "R3");
    step(1, 1, 0, 2'd0, 0, 0, 32'h0000_FFFF, 32'h0000_0001, 0, 0, 0, "R3");
    step(1, 1, 0, 2'd0, 0, 0, 32'hFFFF_FFFF, 32'h0000_0002, 0, 0, 0, "R3");
    // R4
    step(1, 1, 0, 2'd1, 0, 0, 32'hF0F0_1234, 32'hFF00_FF0F, 0, 0, 0, "R4");
    step(1, 0, 0, 2'd1, 0, 0, 32'h0BAD_F00F, 32'h1234_0FF0, 0, 0, 0, "R4");
    // R5: shift boundaries and ignored B[4] in narrow mode
    step(1, 1, 0, 2'd2, 0, 0, 32'h0000_ABCD, 32'd16, 0, 0, 0, "R5");
    step(1, 1, 0, 2'd2, 0, 0, 32'h8000_0001, 32'd31, 0, 0, 0, "R5");
    step(1, 0, 0, 2'd2, 0, 0, 32'h0000_0001, 32'd15, 0, 0, 0, "R5");
    step(1, 0, 0, 2'd2, 0, 0, 32'h0000_0101, 32'h13, 0, 0, 0, "R5");
    // R6: narrow compare on equal low halves, wide compare sees high difference
    step(1, 0, 0, 2'd3, 0, 0, 32'h1111_4444, 32'h2222_4444, 0, 0, 0, "R6");
    step(1, 1, 0, 2'd3, 0, 0, 32'h1111_4444, 32'h2222_4444, 0, 0, 0, "R6");
    step(1, 1, 0, 2'd3, 0, 0, 32'h9999_4444, 32'h9999_4444, 0, 0, 0, "R6");
    // R9: every source code
    step(1, 1, 0, 2'd0, 1, 2, 32'h1, 32'h2, 32'h100, 32'h2000, 0, "R9");
    step(1, 1, 0, 2'd0, 2, 1, 32'h1, 32'h2, 32'h100, 32'h2000, 0, "R9");
    step(1, 1, 0, 2'd0, 3, 0, 32'h1, 32'h2, 32'h100, 32'h2000, 0, "R9");
    // R10: immediate extension
    step(1, 1, 0, 2'd0, 0, 3, 32'h0, 32'h5, 0, 0, 16'h8000, "R10");
    step(1, 0, 0, 2'd0, 0, 3, 32'h0, 32'h5, 0, 0, 16'h8001, "R10");
    // R8: stores of both widths, then a non-store
    step(1, 1, 1, 2'd0, 0, 0, 32'h0, 32'hDEAD_BEEF, 0, 0, 0, "R8");
    step(1, 0, 1, 2'd0, 0, 0, 32'h0, 32'h1234_5678, 0, 0, 0, "R8");
    step(1, 1, 0, 2'd0, 0, 0, 32'h0, 32'hCAFE_CAFE, 0, 0, 0, "R8");
    // R11: idle cycle with busy inputs
    step(0, 1, 1, 2'd3, 0, 0, 32'h7, 32'h7, 32'h7, 32'h7, 16'h7, "R11");

    for (int i = 0; i < 600; i++) begin
      logic [1:0] op;
      op = 2'($urandom_range(0, 3));
      step(($urandom_range(0, 7) != 0), $urandom_range(0, 1), $urandom_range(0, 1), op,
           2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)),
           ($urandom_range(0, 3) == 0) ? 32'h0000_1234 : $urandom,
           ($urandom_range(0, 3) == 0) ? 32'h0000_1234 : $urandom,
           $urandom, $urandom, 16'($urandom), opTag(op));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule